// File: doc/BRIEF.md
# DMA Controller Register and Interrupt Front End

This block is the software-facing side of a multi-channel DMA controller. A 32-bit register bus reaches two regions. One is a per-channel window that holds each channel's transfer setup words and its status word. The other is a global region that holds the controller enable, two sticky error flags, the pending-interrupt word, the fetch doorbell and a few mask and storage words. The channel engines sit behind the block. Each engine receives a one-cycle fetch pulse, a channel enable and the descriptor address it must load from. Each engine reports back through halt, address-error and transfer-done pulses.

A driver sets up a channel's descriptor address and status word, turns the controller on, and rings the doorbell. When an engine reports an event, the block does four things: it records the event in that channel's status, stops the channel, raises the channel's pending bit and, for faults, sets the matching global flag. The single interrupt line is active while the controller is enabled and any pending bit is set.

A two-state bus sequencer paces every access. In state BUS_IDLE a selected access is taken (transition "accept"): a write takes effect at that clock edge and read data is captured. The sequencer then moves to BUS_ACK, which holds the ready strobe for exactly one cycle and returns to BUS_IDLE unconditionally (transition "respond").

Top module: `dma_ctl_regbank`

## Requirements
- R1: After reset, every register reads zero and irq, bus_ready, ch_fetch and ch_enable are low.
- R2: Every access is answered by bus_ready high for exactly one cycle, one cycle after it is accepted. An access is unmapped if any of these holds: address bits [1:0] are nonzero; it falls in the channel region at or beyond channel NCH (offset NCH*0x20); it is a global offset outside 0x1000, 0x1004, 0x1008, 0x100C and 0x101C to 0x102C. Unmapped accesses read zero and writes to them change nothing.
- R3: Channel n's window starts at n*0x20. Word offsets 0x00, 0x04, 0x08, 0x0C, 0x14, 0x18 and 0x1C are 32-bit storage that reads back what was written. The word at 0x18 is the descriptor address and appears on ch_desc_addr[n*32 +: 32].
- R4: The channel status word at offset 0x10 keeps only bit 0 (enable), bit 2 (halt), bit 3 (terminated), bit 4 (address error) and bit 30 (8-word descriptors), so writing all ones reads 0x4000001D. ch_enable[n] equals bit 0, and writing zero clears the word.
- R5: Writing a word to 0x100C while the controller is enabled pulses ch_fetch for one cycle, on the bits that are one, in the cycle after the write. The same bits are set in the doorbell word at 0x1008. While the controller is disabled the write has no effect. 0x100C reads zero. A doorbell bit clears on any engine event of its channel.
- R6: An engine pulse on channel n sets status bit 2 for halt, bit 4 for address error and bit 3 for done, and clears status bit 0.
- R7: Any engine event on channel n sets bit n of the pending word at 0x1004. A write to 0x1004 keeps only the pending bits whose written bit is one, so writing zero clears them all.
- R8: In the control word at 0x1000, bit 0 is the controller enable and bit 31 is plain storage. Bit 2 sets when any channel reports an address error, and bit 3 sets when any channel reports a halt. Both flags stay set until a control write with that bit at zero. Writing a one to a flag never sets it.
- R9: irq is high exactly when the controller enable is set and at least one pending bit is set.
- R10: An engine event that coincides with a software write wins over that write. This holds for a pending clear, for a status-word write and for a control-word flag clear.
- R11: The words at 0x101C, 0x1020, 0x1024, 0x1028 and 0x102C are plain NCH-bit storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 13 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | One-cycle access completion strobe |
| irq | output | 1 | Combined interrupt line |
| ch_fetch | output | NCH | One-cycle descriptor fetch pulses, one per channel |
| ch_enable | output | NCH | Channel run enables |
| ch_desc_addr | output | NCH*32 | Descriptor address of every channel |
| eng_halt | input | NCH | Engine halt pulses |
| eng_addr_err | input | NCH | Engine address-error pulses |
| eng_done | input | NCH | Engine transfer-done pulses |

## Verification
Software writes and engine reports are independent, so a register can be written by software and updated by an engine in the same clock edge. The bench provokes this on purpose. It raises an engine pulse in the same cycle as the bus sequencer accepts each of three writes: a clear of the pending word, a zero write to a channel status word, and a control-word write that clears the flags. Afterwards it reads each word back. A correct design shows the event's bit set and the software write applied to every other bit.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_ACK  = 1'b1
    } bus_state_t;

    // channel window word indices (address bits [4:2])
    localparam logic [2:0] CW_SRC    = 3'd0;
    localparam logic [2:0] CW_DST    = 3'd1;
    localparam logic [2:0] CW_CNT    = 3'd2;
    localparam logic [2:0] CW_REQ    = 3'd3;
    localparam logic [2:0] CW_STAT   = 3'd4;
    localparam logic [2:0] CW_CMD    = 3'd5;
    localparam logic [2:0] CW_DESC   = 3'd6;
    localparam logic [2:0] CW_STRIDE = 3'd7;

    // global word indices (address bits [5:2] above 0x1000)
    localparam logic [3:0] GW_CTRL    = 4'd0;
    localparam logic [3:0] GW_PEND    = 4'd1;
    localparam logic [3:0] GW_BELL    = 4'd2;
    localparam logic [3:0] GW_BELLSET = 4'd3;
    localparam logic [3:0] GW_PROG    = 4'd7;
    localparam logic [3:0] GW_SPEND   = 4'd8;
    localparam logic [3:0] GW_SMASK   = 4'd9;
    localparam logic [3:0] GW_CPEND   = 4'd10;
    localparam logic [3:0] GW_CMASK   = 4'd11;

    // channel status bits
    localparam int ST_EN   = 0;
    localparam int ST_HALT = 2;
    localparam int ST_TERM = 3;
    localparam int ST_AERR = 4;
    localparam int ST_D8   = 30;
    localparam logic [31:0] STAT_KEEP = 32'h4000_001D;

    // control word bits
    localparam int CT_EN   = 0;
    localparam int CT_AERR = 2;
    localparam int CT_HALT = 3;
    localparam int CT_PERF = 31;

endpackage

// File: rtl/dmarb_bus_fsm.sv
module dmarb_bus_fsm
    import dmarb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_sel,
    output logic acc,
    output logic bus_ready
);

    bus_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (bus_sel) state_d = BUS_ACK;   // accept
            BUS_ACK:  state_d = BUS_IDLE;               // respond
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        acc       = 1'b0;
        bus_ready = 1'b0;
        unique case (state_q)
            BUS_IDLE: acc       = bus_sel;
            BUS_ACK:  bus_ready = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/dmarb_chan_slot.sv
module dmarb_chan_slot
    import dmarb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  widx,
    input  logic [31:0] wdata,
    input  logic        ev_halt,
    input  logic        ev_aerr,
    input  logic        ev_done,
    output logic [31:0] rd_word,
    output logic        enable,
    output logic [31:0] desc_addr
);

    localparam int NWORDS = 8;

    logic [31:0] rd_arr [NWORDS];
    logic [31:0] stat_q, stat_d;

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        if (w == int'(CW_STAT)) begin : g_stat
            assign rd_arr[w] = stat_q;
        end else begin : g_store
            logic [31:0] word_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                          word_q <= '0;
                else if (wr_en && widx == 3'(w))     word_q <= wdata;
            end
            assign rd_arr[w] = word_q;
        end
    end

    always_comb begin
        stat_d = stat_q;
        if (wr_en && widx == CW_STAT) stat_d = wdata & STAT_KEEP;
        if (ev_halt) stat_d[ST_HALT] = 1'b1;
        if (ev_aerr) stat_d[ST_AERR] = 1'b1;
        if (ev_done) stat_d[ST_TERM] = 1'b1;
        if (ev_halt || ev_aerr || ev_done) stat_d[ST_EN] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign rd_word   = rd_arr[widx];
    assign enable    = stat_q[ST_EN];
    assign desc_addr = rd_arr[CW_DESC];

endmodule

// File: rtl/dmarb_global.sv
module dmarb_global
    import dmarb_pkg::*;
#(
    parameter int NCH = 32
)(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [3:0]     gidx,
    input  logic [31:0]    wdata,
    input  logic [NCH-1:0] ev_halt_v,
    input  logic [NCH-1:0] ev_aerr_v,
    input  logic [NCH-1:0] ev_done_v,
    output logic [31:0]    rd_word,
    output logic           ctl_en,
    output logic           halt_flag,
    output logic           irq,
    output logic [NCH-1:0] fetch,
    output logic [NCH-1:0] pend
);

    logic en_q, aerr_q, halt_q, perf_q;
    logic en_d, aerr_d, halt_d, perf_d;
    logic [NCH-1:0] pend_q, pend_d, bell_q, bell_d, fetch_q, fetch_d;
    logic [NCH-1:0] prog_q, spend_q, smask_q, cpend_q, cmask_q;
    logic [NCH-1:0] ev_any, wlo;
    logic wc, wp, wb, wbs;

    always_comb begin
        wlo    = wdata[NCH-1:0];
        ev_any = ev_halt_v | ev_aerr_v | ev_done_v;
        wc     = wr_en && gidx == GW_CTRL;
        wp     = wr_en && gidx == GW_PEND;
        wb     = wr_en && gidx == GW_BELL;
        wbs    = wr_en && gidx == GW_BELLSET;
        en_d    = wc ? wdata[CT_EN]   : en_q;
        perf_d  = wc ? wdata[CT_PERF] : perf_q;
        aerr_d  = (wc ? (aerr_q & wdata[CT_AERR]) : aerr_q) | (|ev_aerr_v);
        halt_d  = (wc ? (halt_q & wdata[CT_HALT]) : halt_q) | (|ev_halt_v);
        pend_d  = (wp ? (pend_q & wlo) : pend_q) | ev_any;
        fetch_d = (wbs && en_q) ? wlo : '0;
        bell_d  = ((wb ? (bell_q & wlo) : bell_q) & ~ev_any) | fetch_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            perf_q  <= 1'b0;
            aerr_q  <= 1'b0;
            halt_q  <= 1'b0;
            pend_q  <= '0;
            bell_q  <= '0;
            fetch_q <= '0;
        end else begin
            en_q    <= en_d;
            perf_q  <= perf_d;
            aerr_q  <= aerr_d;
            halt_q  <= halt_d;
            pend_q  <= pend_d;
            bell_q  <= bell_d;
            fetch_q <= fetch_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_q  <= '0;
            spend_q <= '0;
            smask_q <= '0;
            cpend_q <= '0;
            cmask_q <= '0;
        end else if (wr_en) begin
            if (gidx == GW_PROG)  prog_q  <= wlo;
            if (gidx == GW_SPEND) spend_q <= wlo;
            if (gidx == GW_SMASK) smask_q <= wlo;
            if (gidx == GW_CPEND) cpend_q <= wlo;
            if (gidx == GW_CMASK) cmask_q <= wlo;
        end
    end

    always_comb begin
        rd_word = '0;
        case (gidx)
            GW_CTRL: begin
                rd_word[CT_EN]   = en_q;
                rd_word[CT_AERR] = aerr_q;
                rd_word[CT_HALT] = halt_q;
                rd_word[CT_PERF] = perf_q;
            end
            GW_PEND:  rd_word[NCH-1:0] = pend_q;
            GW_BELL:  rd_word[NCH-1:0] = bell_q;
            GW_PROG:  rd_word[NCH-1:0] = prog_q;
            GW_SPEND: rd_word[NCH-1:0] = spend_q;
            GW_SMASK: rd_word[NCH-1:0] = smask_q;
            GW_CPEND: rd_word[NCH-1:0] = cpend_q;
            GW_CMASK: rd_word[NCH-1:0] = cmask_q;
            default:  rd_word = '0;
        endcase
    end

    assign ctl_en    = en_q;
    assign halt_flag = halt_q;
    assign irq       = en_q & (|pend_q);
    assign fetch     = fetch_q;
    assign pend      = pend_q;

endmodule

// File: rtl/dma_ctl_regbank.sv
module dma_ctl_regbank
    import dmarb_pkg::*;
#(
    parameter int NCH = 32
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [12:0]      bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             bus_ready,
    output logic             irq,
    output logic [NCH-1:0]   ch_fetch,
    output logic [NCH-1:0]   ch_enable,
    output logic [NCH*32-1:0] ch_desc_addr,
    input  logic [NCH-1:0]   eng_halt,
    input  logic [NCH-1:0]   eng_addr_err,
    input  logic [NCH-1:0]   eng_done
);

    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    logic        acc, wr_stb;
    logic [6:0]  ch_row;
    logic        ch_hit, g_hit, aligned;
    logic [31:0] ch_rd [NCH];
    logic [31:0] g_rd, rd_val, rdata_q;
    logic        ctl_en, glb_halt;
    logic [NCH-1:0] pend_vec;

    dmarb_bus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .acc       (acc),
        .bus_ready (bus_ready)
    );

    always_comb begin
        aligned = bus_addr[1:0] == 2'b00;
        ch_row  = bus_addr[11:5];
        ch_hit  = aligned && !bus_addr[12] && (ch_row < 7'(NCH));
        g_hit   = aligned && bus_addr[12] && (bus_addr[11:6] == 6'd0);
        wr_stb  = acc && bus_wr;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        dmarb_chan_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_stb && ch_hit && ch_row == 7'(i)),
            .widx      (bus_addr[4:2]),
            .wdata     (bus_wdata),
            .ev_halt   (eng_halt[i]),
            .ev_aerr   (eng_addr_err[i]),
            .ev_done   (eng_done[i]),
            .rd_word   (ch_rd[i]),
            .enable    (ch_enable[i]),
            .desc_addr (ch_desc_addr[i*32 +: 32])
        );
    end

    dmarb_global #(.NCH(NCH)) u_glb (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_stb && g_hit),
        .gidx      (bus_addr[5:2]),
        .wdata     (bus_wdata),
        .ev_halt_v (eng_halt),
        .ev_aerr_v (eng_addr_err),
        .ev_done_v (eng_done),
        .rd_word   (g_rd),
        .ctl_en    (ctl_en),
        .halt_flag (glb_halt),
        .irq       (irq),
        .fetch     (ch_fetch),
        .pend      (pend_vec)
    );

    always_comb begin
        rd_val = '0;
        if (ch_hit)     rd_val = ch_rd[ch_row[CH_W-1:0]];
        else if (g_hit) rd_val = g_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   rdata_q <= '0;
        else if (acc) rdata_q <= bus_wr ? 32'd0 : rd_val;
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/dma_ctl_regbank_chk.sv
module dma_ctl_regbank_chk #(
    parameter int NCH = 32
)(
    input logic           clk,
    input logic           rst_n,
    input logic           bus_ready,
    input logic [NCH-1:0] ch_fetch,
    input logic [NCH-1:0] ch_enable,
    input logic [NCH-1:0] eng_halt,
    input logic [NCH-1:0] eng_addr_err,
    input logic [NCH-1:0] eng_done,
    input logic           ctl_en,
    input logic [NCH-1:0] pend,
    input logic           g_halt
);

    logic [NCH-1:0] ev;
    assign ev = eng_halt | eng_addr_err | eng_done;

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);  // R2

    AST_FETCH_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_fetch) |-> $past(ctl_en));  // R5

    AST_ENABLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev) |=> ((ch_enable & $past(ev)) == '0));  // R6

    AST_PEND_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev) |=> ((pend & $past(ev)) == $past(ev)));  // R7

    AST_HALT_FLAG_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(g_halt) |-> $past(|eng_halt));  // R8

endmodule

bind dma_ctl_regbank dma_ctl_regbank_chk #(.NCH(NCH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_ready    (bus_ready),
    .ch_fetch     (ch_fetch),
    .ch_enable    (ch_enable),
    .eng_halt     (eng_halt),
    .eng_addr_err (eng_addr_err),
    .eng_done     (eng_done),
    .ctl_en       (ctl_en),
    .pend         (pend_vec),
    .g_halt       (glb_halt)
);

// File: tb/test_dma_ctl_regbank.sv
module test_dma_ctl_regbank;

    localparam int NCH = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic bus_ready, irq;
    logic [NCH-1:0] ch_fetch, ch_enable;
    logic [NCH*32-1:0] ch_desc_addr;
    logic [NCH-1:0] eng_halt = '0, eng_addr_err = '0, eng_done = '0;

    always #5 clk = ~clk;

    dma_ctl_regbank #(.NCH(NCH)) i_dma_ctl_regbank (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .irq(irq), .ch_fetch(ch_fetch),
        .ch_enable(ch_enable), .ch_desc_addr(ch_desc_addr),
        .eng_halt(eng_halt), .eng_addr_err(eng_addr_err), .eng_done(eng_done)
    );

    typedef struct {
        bit          is_rd;
        logic [31:0] exp;
        string       rq;
        logic [12:0] addr;
    } item_t;

    item_t sb[$];
    int n_run = 0;
    int n_fail = 0;

    task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", rq, act, exp);
        end
    endtask

    // monitor: every ready pops one scoreboard item
    always @(negedge clk) begin
        if (bus_ready) begin
            if (sb.size() == 0) begin
                check("R2 unexpected ready", 32'd1, 32'd0);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (it.is_rd)
                    check($sformatf("%s read 0x%04h", it.rq, it.addr), bus_rdata, it.exp);
            end
        end
    end

    task automatic access(bit wr, logic [12:0] a, logic [31:0] d, logic [31:0] exp, string rq,
                          logic [NCH-1:0] h, logic [NCH-1:0] ae, logic [NCH-1:0] dn);
        item_t it;
        it.is_rd = !wr; it.exp = exp; it.rq = rq; it.addr = a;
        @(negedge clk);
        sb.push_back(it);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        eng_halt = h; eng_addr_err = ae; eng_done = dn;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        eng_halt = '0; eng_addr_err = '0; eng_done = '0;
    endtask

    task automatic wr(logic [12:0] a, logic [31:0] d);
        access(1'b1, a, d, 32'd0, "", '0, '0, '0);
    endtask

    task automatic rd(logic [12:0] a, logic [31:0] exp, string rq);
        access(1'b0, a, 32'd0, exp, rq, '0, '0, '0);
    endtask

    task automatic pulse(logic [NCH-1:0] h, logic [NCH-1:0] ae, logic [NCH-1:0] dn);
        @(negedge clk);
        eng_halt = h; eng_addr_err = ae; eng_done = dn;
        @(negedge clk);
        eng_halt = '0; eng_addr_err = '0; eng_done = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check("watchdog expired", 32'd1, 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", 32'(irq), 32'd0);
        check("R1 ready", 32'(bus_ready), 32'd0);
        check("R1 ch_enable", ch_enable, 32'd0);
        check("R1 ch_fetch", ch_fetch, 32'd0);
        rd(13'h1000, 32'd0, "R1");
        rd(13'h1004, 32'd0, "R1");
        rd(13'h0070, 32'd0, "R1");

        // R3 channel storage
        wr(13'h00A0, 32'h1234_5678);
        wr(13'h03F8, 32'hCAFE_0040);
        wr(13'h001C, 32'h0BAD_F00D);
        rd(13'h00A0, 32'h1234_5678, "R3");
        rd(13'h03F8, 32'hCAFE_0040, "R3");
        rd(13'h001C, 32'h0BAD_F00D, "R3");
        check("R3 desc addr port ch31", ch_desc_addr[31*32 +: 32], 32'hCAFE_0040);

        // R2 unmapped and ready pulse
        wr(13'h1010, 32'hFFFF_FFFF);
        check("R2 ready high", 32'(bus_ready), 32'd1);
        @(negedge clk);
        check("R2 ready single", 32'(bus_ready), 32'd0);
        rd(13'h1010, 32'd0, "R2");
        wr(13'h0400, 32'hFFFF_FFFF);
        rd(13'h0400, 32'd0, "R2");
        rd(13'h0000, 32'd0, "R2 no alias");
        wr(13'h00A2, 32'hFFFF_FFFF);
        rd(13'h00A0, 32'h1234_5678, "R2 misaligned");

        // R4 status word
        wr(13'h0070, 32'hFFFF_FFFF);
        rd(13'h0070, 32'h4000_001D, "R4");
        check("R4 ch_enable", ch_enable, 32'h0000_0008);
        wr(13'h0070, 32'd0);
        rd(13'h0070, 32'd0, "R4");
        check("R4 ch_enable off", ch_enable, 32'd0);

        // R5 doorbell
        wr(13'h1000, 32'h8000_0001);
        rd(13'h1000, 32'h8000_0001, "R8");
        wr(13'h0058, 32'h1000_0200);
        check("R5 desc addr ch2", ch_desc_addr[2*32 +: 32], 32'h1000_0200);
        wr(13'h100C, 32'h0000_0014);
        check("R5 fetch pulse", ch_fetch, 32'h0000_0014);
        @(negedge clk);
        check("R5 fetch one cycle", ch_fetch, 32'd0);
        rd(13'h1008, 32'h0000_0014, "R5");
        rd(13'h100C, 32'd0, "R5");
        wr(13'h1000, 32'd0);
        wr(13'h100C, 32'h0000_0001);
        check("R5 no fetch when disabled", ch_fetch, 32'd0);
        rd(13'h1008, 32'h0000_0014, "R5");
        wr(13'h1000, 32'h8000_0001);

        // R6 engine events
        wr(13'h0050, 32'h4000_0001);
        check("R6 enable set", ch_enable, 32'h0000_0004);
        pulse('0, '0, 32'h0000_0004);
        check("R6 enable dropped", ch_enable, 32'd0);
        rd(13'h0050, 32'h4000_0008, "R6");
        rd(13'h1008, 32'h0000_0010, "R5 bell cleared by event");
        wr(13'h00F0, 32'h0000_0001);
        pulse(32'h0000_0080, 32'h0000_0080, '0);
        rd(13'h00F0, 32'h0000_0014, "R6");

        // R7 R8 R9
        rd(13'h1004, 32'h0000_0084, "R7");
        check("R9 irq on", 32'(irq), 32'd1);
        rd(13'h1000, 32'h8000_000D, "R8");
        wr(13'h1000, 32'h0000_000C);
        check("R9 irq gated", 32'(irq), 32'd0);
        rd(13'h1000, 32'h0000_000C, "R8");
        wr(13'h1000, 32'h8000_0001);
        rd(13'h1000, 32'h8000_0001, "R8");
        check("R9 irq back", 32'(irq), 32'd1);
        wr(13'h1004, 32'h0000_0080);
        rd(13'h1004, 32'h0000_0080, "R7");
        wr(13'h1004, 32'd0);
        rd(13'h1004, 32'd0, "R7");
        check("R9 irq off", 32'(irq), 32'd0);

        // R10 same-cycle collisions
        access(1'b1, 13'h1004, 32'd0, 32'd0, "", '0, '0, 32'h0000_0200);
        rd(13'h1004, 32'h0000_0200, "R10");
        check("R10 irq", 32'(irq), 32'd1);
        access(1'b1, 13'h0130, 32'd0, 32'd0, "", '0, 32'h0000_0200, '0);
        rd(13'h0130, 32'h0000_0010, "R10");
        access(1'b1, 13'h1000, 32'h8000_0001, 32'd0, "", 32'h0000_0200, '0, '0);
        rd(13'h1000, 32'h8000_0009, "R10");

        // R11 storage words
        wr(13'h101C, 32'hA5A5_A5A5);
        wr(13'h1020, 32'h0000_FFFF);
        wr(13'h1024, 32'h1357_9BDF);
        wr(13'h1028, 32'h8000_0001);
        wr(13'h102C, 32'h7E7E_0000);
        rd(13'h101C, 32'hA5A5_A5A5, "R11");
        rd(13'h1020, 32'h0000_FFFF, "R11");
        rd(13'h1024, 32'h1357_9BDF, "R11");
        rd(13'h1028, 32'h8000_0001, "R11");
        rd(13'h102C, 32'h7E7E_0000, "R11");

        repeat (3) @(negedge clk);
        check("scoreboard drained", 32'(sb.size()), 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule